// File: doc/BRIEF.md
# Predication Lookup Table Builder

This block keeps a short list of predication settings, each a key-value pair written through a register-style write port. A key names one architectural register, integer or floating point. The value names the integer register that holds the mask, and carries an invert flag, a zeroing flag and a bank bit. Execution logic needs to answer one question for every operand: "is this register predicated, and how?" A list cannot answer that in one step, so the block expands the list into a dense table with one row per register. There are 32 integer rows and 32 floating-point rows.

Every write to the list starts a rebuild. The rebuild clears a working copy of the table and then applies the list entries one per cycle in ascending index order. When the walk ends, the working copy replaces the live table in one step. A combinational lookup port reads the live table, so an operand lookup always sees a complete table and never a half-built one. A busy flag shows while a rebuild is in flight.

Top module: `pred_table_expander`

## Requirements
- R1: After reset, busy is 0 and every one of the 64 lookups returns enable, invert, zeroing, bank and predicate register all zero. Every list slot resets with its bank bit set to 1, so an unwritten slot never reaches the table.
- R2: Once a rebuild finishes, a lookup of the type and key held by a written slot whose bank bit is 0 returns enable=1. It also returns that slot's predicate register, invert and zeroing values, with bank=0.
- R3: A slot with type 0 fills integer row key, selected by lk_fp=0. A slot with type 1 fills floating-point row key, selected by lk_fp=1. The row with the same key in the other table is left untouched.
- R4: Each rebuild starts from an all-cleared table. A row whose key no longer appears in any active slot reads enable=0 after the rebuild.
- R5: If several active slots share the same type and key, the slot with the highest index decides the row.
- R6: A slot whose bank bit is 1 is skipped during the walk and has no effect on any row.
- R7: busy goes high on the cycle after a write. It stays high for exactly 18 cycles: one clear, 16 apply cycles and one commit. It is then low.
- R8: While busy is high, lookups return the table from the previous finished rebuild.
- R9: A write that arrives during a rebuild restarts the walk. busy then stays high for 18 cycles counted from that write, and the final table reflects both writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one list slot |
| wr_idx | input | 4 | Slot index to write |
| wr_fp | input | 1 | Slot type: 0 integer, 1 floating point |
| wr_key | input | 5 | Register the slot predicates |
| wr_pred | input | 5 | Integer register holding the mask |
| wr_inv | input | 1 | Invert the mask |
| wr_zero | input | 1 | Zero masked-off elements |
| wr_bank | input | 1 | Bank bit; 1 is reserved and skipped |
| busy | output | 1 | Rebuild in progress |
| lk_fp | input | 1 | Lookup table select |
| lk_reg | input | 5 | Lookup register number |
| lk_en | output | 1 | Row is predicated |
| lk_inv | output | 1 | Row invert flag |
| lk_zero | output | 1 | Row zeroing flag |
| lk_bank | output | 1 | Row bank field |
| lk_pred | output | 5 | Row predicate register |

## Verification
The hardest situation to reach is a rebuild interrupted part way through. In that case the working copy holds a partial table, the live table must still show the old one, and the final result must still include both writes. The bench writes a slot, waits a few cycles into the apply walk, and writes a second slot. It then measures busy from the second write and looks up both keys. Overwrite-by-index is reached by placing the same key in slots 0 and 2. A slot is then moved away to show that the lower slot takes the row back.

// File: rtl/pte_pkg.sv
package pte_pkg;
  localparam int NUM_SLOTS = 16;
  localparam int REG_W     = 5;
  localparam int NUM_REGS  = 1 << REG_W;
  localparam int NUM_ROWS  = 2 * NUM_REGS;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int ROW_W     = $clog2(NUM_ROWS);

  typedef struct packed {
    logic             bank;
    logic             zero;
    logic             inv;
    logic [REG_W-1:0] pred;
    logic [REG_W-1:0] key;
    logic             fp;
  } slot_t;

  typedef struct packed {
    logic             en;
    logic             bank;
    logic             zero;
    logic             inv;
    logic [REG_W-1:0] pred;
  } row_t;

  // Floating-point rows sit above the integer rows.
  function automatic logic [ROW_W-1:0] row_of(input logic fp, input logic [REG_W-1:0] key);
    return {fp, key};
  endfunction

  function automatic row_t row_from_slot(input slot_t s);
    row_t r;
    r.en   = 1'b1;
    r.bank = s.bank;
    r.zero = s.zero;
    r.inv  = s.inv;
    r.pred = s.pred;
    return r;
  endfunction

  // Inert slot value used at reset (reserved bank).
  function automatic slot_t idle_slot();
    slot_t s;
    s      = '0;
    s.bank = 1'b1;
    return s;
  endfunction
endpackage

// File: rtl/pte_slot_store.sv
module pte_slot_store
  import pte_pkg::*;
#(
  parameter int SLOTS = NUM_SLOTS,
  localparam int IW   = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  slot_t         wr_slot,
  input  logic [IW-1:0] rd_idx,
  output slot_t         rd_slot
);
  slot_t mem_q [SLOTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) mem_q[i] <= idle_slot();
    end else if (wr_en) begin
      mem_q[wr_idx] <= wr_slot;
    end
  end

  assign rd_slot = mem_q[rd_idx];
endmodule

// File: rtl/pte_walker.sv
module pte_walker
  import pte_pkg::*;
#(
  parameter int SLOTS = NUM_SLOTS,
  localparam int IW   = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          clear,
  output logic          apply,
  output logic [IW-1:0] apply_idx,
  output logic          commit,
  output logic          busy
);
  typedef enum logic [1:0] {W_IDLE, W_CLEAR, W_APPLY, W_COMMIT} wstate_t;
  wstate_t       state_q;
  logic [IW-1:0] idx_q;
  logic          last_slot;

  assign last_slot = (idx_q == IW'(SLOTS - 1));
  assign busy      = (state_q != W_IDLE);
  assign clear     = (state_q == W_CLEAR);
  assign apply     = (state_q == W_APPLY);
  assign apply_idx = idx_q;
  // A restart during the commit cycle keeps the old live table.
  assign commit    = (state_q == W_COMMIT) && !start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= W_IDLE;
      idx_q   <= '0;
    end else if (start) begin
      state_q <= W_CLEAR;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        W_CLEAR:  state_q <= W_APPLY;
        W_APPLY: begin
          if (last_slot) state_q <= W_COMMIT;
          else           idx_q   <= idx_q + 1'b1;
        end
        W_COMMIT: state_q <= W_IDLE;
        default:  state_q <= W_IDLE;
      endcase
    end
  end

  a_r7_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  a_r7_idle_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);
  a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> clear);
endmodule

// File: rtl/pte_table.sv
module pte_table
  import pte_pkg::*;
#(
  parameter int ROWS = NUM_ROWS,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          apply,
  input  slot_t         apply_slot,
  input  logic          commit,
  input  logic [RW-1:0] lk_row,
  output row_t          lk_out
);
  row_t [ROWS-1:0] shadow_q;
  row_t [ROWS-1:0] live_q;
  logic            apply_go;
  logic [RW-1:0]   apply_row;

  assign apply_go  = apply && !apply_slot.bank;
  assign apply_row = RW'(row_of(apply_slot.fp, apply_slot.key));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (clear) begin
      shadow_q <= '0;
    end else if (apply_go) begin
      shadow_q[apply_row] <= row_from_slot(apply_slot);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      live_q <= '0;
    else if (commit) live_q <= shadow_q;
  end

  assign lk_out = live_q[lk_row];

  a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (shadow_q == '0));
  a_r2_row_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    apply_go |=> shadow_q[$past(apply_row)].en);
  a_r6_reserved_skipped: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && apply_slot.bank && !clear) |=> $stable(shadow_q));
  a_r8_live_held: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(live_q));
endmodule

// File: rtl/pred_table_expander.sv
module pred_table_expander
  import pte_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SLOT_W-1:0] wr_idx,
  input  logic             wr_fp,
  input  logic [REG_W-1:0] wr_key,
  input  logic [REG_W-1:0] wr_pred,
  input  logic             wr_inv,
  input  logic             wr_zero,
  input  logic             wr_bank,
  output logic             busy,
  input  logic             lk_fp,
  input  logic [REG_W-1:0] lk_reg,
  output logic             lk_en,
  output logic             lk_inv,
  output logic             lk_zero,
  output logic             lk_bank,
  output logic [REG_W-1:0] lk_pred
);
  slot_t             wr_slot, walk_slot;
  logic              walk_clear, walk_apply, walk_commit;
  logic [SLOT_W-1:0] walk_idx;
  row_t              row_out;

  assign wr_slot = '{bank: wr_bank, zero: wr_zero, inv: wr_inv,
                     pred: wr_pred, key: wr_key, fp: wr_fp};

  pte_slot_store #(.SLOTS(NUM_SLOTS)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_slot(wr_slot), .rd_idx(walk_idx), .rd_slot(walk_slot));

  pte_walker #(.SLOTS(NUM_SLOTS)) u_walker (
    .clk(clk), .rst_n(rst_n), .start(wr_en), .clear(walk_clear),
    .apply(walk_apply), .apply_idx(walk_idx), .commit(walk_commit), .busy(busy));

  pte_table #(.ROWS(NUM_ROWS)) u_table (
    .clk(clk), .rst_n(rst_n), .clear(walk_clear), .apply(walk_apply),
    .apply_slot(walk_slot), .commit(walk_commit),
    .lk_row(row_of(lk_fp, lk_reg)), .lk_out(row_out));

  assign lk_en   = row_out.en;
  assign lk_inv  = row_out.inv;
  assign lk_zero = row_out.zero;
  assign lk_bank = row_out.bank;
  assign lk_pred = row_out.pred;

  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !busy);
endmodule

// File: tb/test_pred_table_expander.sv
module test_pred_table_expander;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 0, wr_fp = 0, wr_inv = 0, wr_zero = 0, wr_bank = 0;
  logic [3:0] wr_idx = 0;
  logic [4:0] wr_key = 0, wr_pred = 0;
  logic       busy;
  logic       lk_fp = 0;
  logic [4:0] lk_reg = 0;
  logic       lk_en, lk_inv, lk_zero, lk_bank;
  logic [4:0] lk_pred;
  int         errors = 0, checks = 0;

  always #2 clk = ~clk;

  pred_table_expander i_pred_table_expander (.*);

  // Each vector: slot write, then one lookup and its expected row {en,inv,zero,pred}.
  typedef struct packed {
    logic [3:0] idx; logic fp; logic [4:0] key; logic [4:0] pred;
    logic inv; logic zero; logic bank;
    logic cfp; logic [4:0] creg;
    logic een; logic einv; logic ezero; logic [4:0] epred;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'd0, 1'b0, 5'd3,  5'd7,  1'b1, 1'b0, 1'b0, 1'b0, 5'd3,  1'b1, 1'b1, 1'b0, 5'd7,  4'd2},
    '{4'd1, 1'b1, 5'd3,  5'd9,  1'b0, 1'b1, 1'b0, 1'b1, 5'd3,  1'b1, 1'b0, 1'b1, 5'd9,  4'd3},
    '{4'd2, 1'b0, 5'd3,  5'd12, 1'b0, 1'b1, 1'b0, 1'b0, 5'd3,  1'b1, 1'b0, 1'b1, 5'd12, 4'd5},
    '{4'd2, 1'b0, 5'd20, 5'd1,  1'b0, 1'b0, 1'b0, 1'b0, 5'd3,  1'b1, 1'b1, 1'b0, 5'd7,  4'd5},
    '{4'd0, 1'b0, 5'd5,  5'd2,  1'b1, 1'b1, 1'b0, 1'b0, 5'd3,  1'b0, 1'b0, 1'b0, 5'd0,  4'd4},
    '{4'd3, 1'b1, 5'd31, 5'd31, 1'b1, 1'b1, 1'b1, 1'b1, 5'd31, 1'b0, 1'b0, 1'b0, 5'd0,  4'd6},
    '{4'd15,1'b1, 5'd31, 5'd4,  1'b1, 1'b1, 1'b0, 1'b1, 5'd31, 1'b1, 1'b1, 1'b1, 5'd4,  4'd3},
    '{4'd14,1'b0, 5'd0,  5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b1, 1'b0, 1'b0, 5'd0,  4'd2}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_slot(input logic [3:0] idx, input logic fp, input logic [4:0] key,
                            input logic [4:0] pred, input logic inv, input logic zero,
                            input logic bank);
    @(negedge clk);
    wr_en = 1; wr_idx = idx; wr_fp = fp; wr_key = key;
    wr_pred = pred; wr_inv = inv; wr_zero = zero; wr_bank = bank;
    @(negedge clk);
    wr_en = 0;
  endtask

  // Called right after write_slot returns; counts negedges with busy high.
  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  // Packs {en,inv,zero,bank,pred}.
  task automatic look(input logic fp, input logic [4:0] r, output logic [8:0] got);
    lk_fp = fp; lk_reg = r;
    #1;
    got = {lk_en, lk_inv, lk_zero, lk_bank, lk_pred};
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [8:0] got, exp;
    int n, bad;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    check(busy == 1'b0, "R1 busy", busy, 0);
    bad = 0;
    for (int t = 0; t < 64; t++) begin
      look(t[5], t[4:0], got);
      if (got != 9'd0) bad++;
    end
    check(bad == 0, "R1 rows cleared", bad, 0);

    // Vector walk: R2 R3 R4 R5 R6
    for (int v = 0; v < 8; v++) begin
      write_slot(VECS[v].idx, VECS[v].fp, VECS[v].key, VECS[v].pred,
                 VECS[v].inv, VECS[v].zero, VECS[v].bank);
      busy_len(n);
      check(n == 18, $sformatf("R7 busy vec%0d", v), n, 18);
      @(negedge clk);
      look(VECS[v].cfp, VECS[v].creg, got);
      exp = {VECS[v].een, VECS[v].einv, VECS[v].ezero, 1'b0, VECS[v].epred};
      check(got == exp, $sformatf("R%0d vec%0d", VECS[v].req, v), got, exp);
      if (v == 0) begin
        look(1'b1, 5'd3, got);
        check(got == 9'd0, "R3 fp row untouched", got, 0);
      end
    end

    // R8: previous table visible during rebuild (int5 = pred2 inv zero)
    write_slot(4'd0, 1'b0, 5'd5, 5'd10, 1'b0, 1'b0, 1'b0);
    bad = 0;
    for (int c = 0; c < 17; c++) begin
      look(1'b0, 5'd5, got);
      if (got != {1'b1, 1'b1, 1'b1, 1'b0, 5'd2}) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R8 old table during busy", bad, 0);
    @(negedge clk);
    look(1'b0, 5'd5, got);
    check(got == {1'b1, 1'b0, 1'b0, 1'b0, 5'd10}, "R8 new table after", got,
          {1'b1, 1'b0, 1'b0, 1'b0, 5'd10});

    // R9: restart mid-walk
    write_slot(4'd4, 1'b0, 5'd8, 5'd3, 1'b0, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    write_slot(4'd5, 1'b0, 5'd9, 5'd6, 1'b1, 1'b0, 1'b0);
    busy_len(n);
    check(n == 18, "R9 busy from restart", n, 18);
    @(negedge clk);
    look(1'b0, 5'd8, got);
    check(got == {1'b1, 1'b0, 1'b0, 1'b0, 5'd3}, "R9 first write", got,
          {1'b1, 1'b0, 1'b0, 1'b0, 5'd3});
    look(1'b0, 5'd9, got);
    check(got == {1'b1, 1'b1, 1'b0, 1'b0, 5'd6}, "R9 second write", got,
          {1'b1, 1'b1, 1'b0, 1'b0, 5'd6});

    // R6: reserved slot moved onto an active key removes nothing but adds nothing
    write_slot(4'd5, 1'b0, 5'd8, 5'd1, 1'b1, 1'b1, 1'b1);
    busy_len(n);
    @(negedge clk);
    look(1'b0, 5'd8, got);
    check(got == {1'b1, 1'b0, 1'b0, 1'b0, 5'd3}, "R6 reserved ignored", got,
          {1'b1, 1'b0, 1'b0, 1'b0, 5'd3});
    look(1'b0, 5'd9, got);
    check(got == 9'd0, "R4 old key cleared", got, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule